// File: doc/BRIEF.md
# Backplane Bus Ownership Arbiter

This block decides which module may drive a shared parallel backplane bus next. Modules sit in four request levels. Each level is a chain of module slots, and slot 0 is electrically nearest the arbiter. A module asks for the bus by pulling its own active-low request line. A level counts as requesting while any of its modules holds its line low, which matches the wired behaviour of a shared open-drain level line.

Choosing a winner takes two stages. First, the block picks one level, either by fixed priority or by round-robin rotation, as selected by a run-time mode input. Second, it sends a grant into that level's chain. The grant passes by idle slots and stops at the first slot that is requesting. The winning module then pulls the shared active-low busy line. The block drops the grant once it sees busy, and it does not arbitrate again until busy is released.

Top module: `backplane_arbiter`

## Requirements
- R1: A level is active while any of its module request lines (`mod_req_n_i`, module index = level*SLOTS_PER_LVL + slot) is low. When the bus is idle and not busy, a registered level grant appears one cycle after the request is sampled.
- R2: With `mode_rr_i` = 0, the highest-numbered active level wins. Level 3 is highest and level 0 is lowest.
- R3: With `mode_rr_i` = 1, the search starts at the level after the one most recently granted, and wraps from 3 to 0. Every grant updates this history, whichever mode produced it.
- R4: Reset clears all grant outputs, leaves the bus idle, and sets the rotation start so that the first round-robin search begins at level 0.
- R5: Within the granted level, the requesting slot with the lowest slot number receives `mod_grant_o`. Non-requesting slots pass the grant on. If no slot on the chain requests, the grant leaves the chain end on `chain_end_o`.
- R6: No new level grant is issued while `busy_n_i` is low. This holds whoever is holding it.
- R7: The level grant is removed on the cycle after busy is first sampled low while a grant is out.
- R8: After the owner releases busy, arbitration resumes one cycle later. With requests pending, the next grant appears two cycles after the release is sampled.
- R9: If the granted level stops requesting before busy is asserted, the grant is withdrawn on the next cycle and the bus returns to idle.
- R10: At most one level grant and at most one module grant are active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_rr_i | input | 1 | Level policy: 0 fixed priority, 1 round-robin |
| mod_req_n_i | input | 4*SLOTS_PER_LVL | Active-low request per module slot, level-major |
| busy_n_i | input | 1 | Active-low shared bus-busy line |
| lvl_grant_o | output | 4 | Grant driven into the head of each level chain |
| mod_grant_o | output | 4*SLOTS_PER_LVL | Grant consumed by each module slot |
| chain_end_o | output | 4 | Grant that fell off the far end of each chain |

## Verification
The hardest condition to reach from the ports is the round-robin rotation at each pointer position, including the wrap from level 3 to level 0. The pointer is never visible, so the only way to set it is a chosen history of grants. The stimulus table therefore runs an ordered series of claim-and-release rounds. With all levels requesting, each round moves the rotation by one known step. A second hard case is the release window after ownership, where requests stay pending across the busy release. Reaching it needs requests held through the whole claim and then busy dropped at a chosen edge, so that the one idle cycle can be observed.

// File: rtl/bparb_pkg.sv
package bparb_pkg;

  localparam int LVL_N = 4;
  localparam int LVL_W = $clog2(LVL_N);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_OWNED = 2'd2
  } own_st_e;

  typedef struct packed {
    logic             hit;
    logic [LVL_W-1:0] lvl;
  } pick_t;

  // highest active index wins: later iterations override earlier ones
  function automatic pick_t pick_fixed(input logic [LVL_N-1:0] act);
    pick_t r;
    r = '0;
    for (int i = 0; i < LVL_N; i++) begin
      if (act[i]) begin
        r.hit = 1'b1;
        r.lvl = LVL_W'(i);
      end
    end
    return r;
  endfunction

  // first active index at or after start, wrapping; scan downward so the
  // smallest distance is assigned last
  function automatic pick_t pick_rotate(input logic [LVL_N-1:0] act,
                                        input logic [LVL_W-1:0] start);
    pick_t r;
    int    idx;
    r = '0;
    for (int k = LVL_N - 1; k >= 0; k--) begin
      idx = (int'(start) + k) % LVL_N;
      if (act[idx]) begin
        r.hit = 1'b1;
        r.lvl = LVL_W'(idx);
      end
    end
    return r;
  endfunction

  function automatic logic [LVL_W-1:0] after_lvl(input logic [LVL_W-1:0] l);
    return LVL_W'((int'(l) + 1) % LVL_N);
  endfunction

endpackage

// File: rtl/bparb_level_pick.sv
module bparb_level_pick
  import bparb_pkg::*;
(
  input  logic [LVL_N-1:0] lvl_act_i,
  input  logic             mode_rr_i,
  input  logic [LVL_W-1:0] rr_start_i,
  output pick_t            pick_o
);

  pick_t fixed_res;
  pick_t rot_res;

  always_comb begin
    fixed_res = pick_fixed(lvl_act_i);
    rot_res   = pick_rotate(lvl_act_i, rr_start_i);
    pick_o    = mode_rr_i ? rot_res : fixed_res;
  end

endmodule

// File: rtl/bparb_owner_fsm.sv
module bparb_owner_fsm
  import bparb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_rr_i,
  input  logic [LVL_N-1:0] lvl_act_i,
  input  logic             busy_i,
  output logic [LVL_N-1:0] lvl_grant_o
);

  own_st_e          state_q;
  logic [LVL_W-1:0] cur_lvl_q;
  logic [LVL_W-1:0] rr_start_q;
  pick_t            pick;

  // named events for the checks below
  logic arb_fire;
  logic claim_seen;
  logic withdraw_seen;
  logic release_seen;

  bparb_level_pick u_pick (
    .lvl_act_i  (lvl_act_i),
    .mode_rr_i  (mode_rr_i),
    .rr_start_i (rr_start_q),
    .pick_o     (pick)
  );

  assign arb_fire      = (state_q == ST_IDLE)  && !busy_i && pick.hit;
  assign claim_seen    = (state_q == ST_GRANT) && busy_i;
  assign withdraw_seen = (state_q == ST_GRANT) && !busy_i && !lvl_act_i[cur_lvl_q];
  assign release_seen  = (state_q == ST_OWNED) && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_lvl_q  <= '0;
      rr_start_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (arb_fire) begin
            state_q    <= ST_GRANT;
            cur_lvl_q  <= pick.lvl;
            rr_start_q <= after_lvl(pick.lvl);
          end
        end
        ST_GRANT: begin
          if (claim_seen)         state_q <= ST_OWNED;
          else if (withdraw_seen) state_q <= ST_IDLE;
        end
        ST_OWNED: begin
          if (release_seen) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    lvl_grant_o = '0;
    if (state_q == ST_GRANT) lvl_grant_o[cur_lvl_q] = 1'b1;
  end

  a_r6_no_grant_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|lvl_grant_o) |-> !$past(busy_i));

  a_r7_grant_drops_after_claim: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lvl_grant_o) && busy_i) |=> !(|lvl_grant_o));

  a_r10_single_level_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lvl_grant_o));

  a_r2_fixed_top_level: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|lvl_grant_o) && !$past(mode_rr_i)) |->
      (($past(lvl_act_i) & ~(lvl_grant_o | (lvl_grant_o - 1'b1))) == '0));

  a_r8_idle_cycle_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_seen |=> !(|lvl_grant_o));

  a_r9_withdraw_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lvl_grant_o) && !busy_i && ((lvl_grant_o & lvl_act_i) == '0)) |=> !(|lvl_grant_o));

  a_r1_grant_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
    arb_fire |=> (|lvl_grant_o));

endmodule

// File: rtl/bparb_daisy_chain.sv
module bparb_daisy_chain #(
  parameter int SLOTS = 3
) (
  input  logic             grant_in_i,
  input  logic [SLOTS-1:0] req_i,
  output logic [SLOTS-1:0] mod_grant_o,
  output logic             grant_out_o
);

  logic [SLOTS:0] pass;

  // slot 0 is nearest the arbiter; an idle slot hands the grant onward
  always_comb begin
    pass[0] = grant_in_i;
    for (int s = 0; s < SLOTS; s++) begin
      mod_grant_o[s] = pass[s] & req_i[s];
      pass[s+1]      = pass[s] & ~req_i[s];
    end
    grant_out_o = pass[SLOTS];
  end

endmodule

// File: rtl/backplane_arbiter.sv
module backplane_arbiter
  import bparb_pkg::*;
#(
  parameter int SLOTS_PER_LVL = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             mode_rr_i,
  input  logic [LVL_N*SLOTS_PER_LVL-1:0]   mod_req_n_i,
  input  logic                             busy_n_i,
  output logic [LVL_N-1:0]                 lvl_grant_o,
  output logic [LVL_N*SLOTS_PER_LVL-1:0]   mod_grant_o,
  output logic [LVL_N-1:0]                 chain_end_o
);

  localparam int MOD_N = LVL_N * SLOTS_PER_LVL;

  logic [MOD_N-1:0] mod_req;
  logic [LVL_N-1:0] lvl_act;
  logic             busy;
  logic [LVL_N-1:0] lvl_grant;

  assign mod_req = ~mod_req_n_i;
  assign busy    = ~busy_n_i;

  bparb_owner_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_rr_i   (mode_rr_i),
    .lvl_act_i   (lvl_act),
    .busy_i      (busy),
    .lvl_grant_o (lvl_grant)
  );

  assign lvl_grant_o = lvl_grant;

  for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
    assign lvl_act[l] = |mod_req[l*SLOTS_PER_LVL +: SLOTS_PER_LVL];

    bparb_daisy_chain #(.SLOTS(SLOTS_PER_LVL)) u_chain (
      .grant_in_i  (lvl_grant[l]),
      .req_i       (mod_req[l*SLOTS_PER_LVL +: SLOTS_PER_LVL]),
      .mod_grant_o (mod_grant_o[l*SLOTS_PER_LVL +: SLOTS_PER_LVL]),
      .grant_out_o (chain_end_o[l])
    );

    a_r5_chain_single_taker: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mod_grant_o[l*SLOTS_PER_LVL +: SLOTS_PER_LVL]));

    a_r5_end_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      chain_end_o[l] |-> !lvl_act[l]);
  end

  a_r10_single_module_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mod_grant_o));

  a_r5_taker_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_grant_o & mod_req_n_i) == '0);

endmodule

// File: tb/backplane_arbiter_tb.sv
module backplane_arbiter_tb_top;

  localparam int CLK_P = 10;
  localparam int SL    = 3;
  localparam int MN    = 4 * SL;
  localparam int NV    = 12;

  // {mode_rr, request pattern (active high), expected module grant}
  localparam logic [24:0] VEC_TAB [0:NV-1] = '{
    {1'b0, 12'h142, 12'h040},
    {1'b0, 12'h808, 12'h800},
    {1'b1, 12'h401, 12'h001},
    {1'b1, 12'h204, 12'h200},
    {1'b1, 12'h016, 12'h002},
    {1'b1, 12'hFFF, 12'h008},
    {1'b1, 12'hFFF, 12'h040},
    {1'b1, 12'hFFF, 12'h200},
    {1'b1, 12'hFFF, 12'h001},
    {1'b0, 12'h004, 12'h004},
    {1'b0, 12'hFFF, 12'h200},
    {1'b1, 12'h0A0, 12'h020}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_rr = 1'b0;
  logic [MN-1:0] mod_req_n = '1;
  logic          busy_n = 1'b1;
  logic [3:0]    lvl_grant;
  logic [MN-1:0] mod_grant;
  logic [3:0]    chain_end;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  backplane_arbiter #(.SLOTS_PER_LVL(SL)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_rr_i   (mode_rr),
    .mod_req_n_i (mod_req_n),
    .busy_n_i    (busy_n),
    .lvl_grant_o (lvl_grant),
    .mod_grant_o (mod_grant),
    .chain_end_o (chain_end)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mod_req_n = '1; busy_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired (all requirements)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R4: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset level grants", 32'(lvl_grant), 32'h0);
    chk("R4 reset module grants", 32'(mod_grant), 32'h0);
    chk("R4 reset chain ends", 32'(chain_end), 32'h0);

    // table walk: R1, R2, R3, R5 grant, R7 drop, R6 hold-off
    for (int v = 0; v < NV; v++) begin
      mode_rr   = VEC_TAB[v][24];
      mod_req_n = ~VEC_TAB[v][23:12];
      @(negedge clk);
      chk(mode_rr ? "R3 R5 R1 rotate grant" : "R2 R5 R1 fixed grant",
          32'(mod_grant), 32'(VEC_TAB[v][11:0]));
      busy_n = 1'b0;
      @(negedge clk);
      chk("R7 grant removed after claim", 32'(lvl_grant), 32'h0);
      mod_req_n = '0;
      repeat (2) @(negedge clk);
      chk("R6 no grant while owner busy", 32'(lvl_grant), 32'h0);
      busy_n = 1'b1; mod_req_n = '1;
      repeat (2) @(negedge clk);
    end

    // R4: rotation starts at level 0 after reset
    do_reset();
    mode_rr = 1'b1;
    mod_req_n = ~12'h201;
    @(negedge clk);
    chk("R4 first rotate search at level 0", 32'(mod_grant), 32'h001);

    // R8: requests held through claim and release
    busy_n = 1'b0;
    @(negedge clk);
    mod_req_n = '0;
    repeat (2) @(negedge clk);
    busy_n = 1'b1;
    @(negedge clk);
    chk("R8 idle cycle after release", 32'(lvl_grant), 32'h0);
    @(negedge clk);
    chk("R8 grant two cycles after release", 32'(lvl_grant), 32'h2);
    chk("R3 rotate after level 0", 32'(mod_grant), 32'h008);
    busy_n = 1'b0;
    @(negedge clk);
    busy_n = 1'b1; mod_req_n = '1;
    repeat (2) @(negedge clk);

    // R6: busy held by another party while idle
    mode_rr = 1'b0;
    busy_n = 1'b0;
    mod_req_n = ~12'h001;
    repeat (3) @(negedge clk);
    chk("R6 no grant under foreign busy", 32'(lvl_grant), 32'h0);
    busy_n = 1'b1;
    @(negedge clk);
    chk("R6 grant once foreign busy drops", 32'(mod_grant), 32'h001);

    // R9 and R5: withdrawal before claim, grant falls off chain end
    mod_req_n = '1;
    #1;
    chk("R5 idle chain passes grant to end", 32'(chain_end), 32'h1);
    @(negedge clk);
    chk("R9 grant withdrawn", 32'(lvl_grant), 32'h0);
    chk("R9 chain end clear", 32'(chain_end), 32'h0);

    // R10: only one module grant with every slot requesting
    mod_req_n = '0;
    @(negedge clk);
    chk("R10 single module grant", 32'($countones(mod_grant)), 32'd1);
    chk("R2 top level nearest slot", 32'(mod_grant), 32'h200);
    mod_req_n = '1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule